// File: doc/BRIEF.md
# Polarity-Violation Frame Aligner

This block sits behind the slicer of a pseudo-ternary line receiver. Each bit period it gets one strobe, `bit_en`, together with two mark qualifiers, one for each polarity. From these it recovers the binary stream. A mark decodes as zero and a space decodes as one. The block flags every mark that repeats the polarity of the mark before it.

Frame boundaries are found from those polarity violations rather than from a sync word. The first violation seen while hunting starts a candidate frame. The candidate becomes alignment once the following frames also show a violation at bit position zero. While aligned, the block expects at most one further violation in a short window after the framing bit. The width of that window depends on the link direction: 14 bits for network-to-terminal and 13 bits for terminal-to-network. Any other violation while aligned is counted as a line error. Frame length and the acquisition and loss thresholds are parameters.

Top module: `lcv_frame_sync`

## Requirements
- R1: For a strobed symbol, `rx_data` is 0 when exactly one mark input is high and 1 when neither is high. All outputs update on the second rising clock edge after the `bit_en` cycle and hold until the next symbol.
- R2: `viol` is 1 for a mark whose polarity equals that of the most recent valid mark. `mark_p` is positive and `mark_n` is negative. The first mark after reset never raises `viol`.
- R3: A symbol with both mark inputs high raises `illegal`, gives `rx_data` = 0 and `viol` = 0, and leaves the remembered polarity unchanged.
- R4: `bit_pos` advances by one per symbol and wraps from FRAME_LEN-1 (default 47) to 0. `frame_start` is 1 exactly for symbols at `bit_pos` 0 while a candidate or locked alignment exists.
- R5: While hunting, any violation sets `bit_pos` to 0 and starts a candidate. `in_sync` rises at the framing symbol of the SYNC_HITS-th consecutive frame (default 3) that has a violation at position 0.
- R6: While locked, `in_sync` falls at position 0 of the LOSS_MISSES-th consecutive frame (default 3) with no violation there. That symbol shows `frame_start` = 0.
- R7: While locked, the first violation at offset 2 to SPAN after the framing bit is accepted without error. SPAN is 14 when NT_TO_TE = 1 and 13 when NT_TO_TE = 0.
- R8: While locked, every other violation away from position 0 increments `err_count` by one. The counter saturates at all ones.
- R9: After reset, `rx_data` = 1 and `viol`, `illegal`, `bit_pos`, `frame_start`, `in_sync` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per received bit |
| mark_p | input | 1 | Positive mark detected |
| mark_n | input | 1 | Negative mark detected |
| rx_data | output | 1 | Recovered binary bit |
| viol | output | 1 | Bipolar violation on this symbol |
| illegal | output | 1 | Both mark inputs high |
| bit_pos | output | $clog2(FRAME_LEN) | Position of this symbol within the frame |
| frame_start | output | 1 | Symbol is at frame position 0 |
| in_sync | output | 1 | Frame alignment locked |
| err_count | output | ERR_W | Saturating count of unexpected violations |

## Verification
Mixed marks, spaces, forced violations and double-mark symbols separate the decoder's polarity memory from its data mapping. They also show that an illegal symbol leaves that memory untouched. Frames carry the second violation at offsets 1, 2, 5, 13, 14 and 15, plus extra violations inside and outside the window. Two instances, one per direction, receive the same stream, so offset 14 is accepted by one and counted by the other. Runs of frames that keep or drop the framing violation pin down the exact symbol at which lock is gained and lost.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2
  } align_state_t;

  typedef struct packed {
    logic data;
    logic viol;
    logic illegal;
  } sym_t;

  localparam sym_t SYM_IDLE = '{data: 1'b1, viol: 1'b0, illegal: 1'b0};
endpackage

// File: rtl/lcv_ami_decoder.sv
module lcv_ami_decoder
  import lcv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic mark_p,
  input  logic mark_n,
  output sym_t sym_o,
  output logic sym_vld_o
);
  logic have_mark_q;
  logic last_neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_o       <= SYM_IDLE;
      sym_vld_o   <= 1'b0;
      have_mark_q <= 1'b0;
      last_neg_q  <= 1'b0;
    end else begin
      sym_vld_o <= bit_en;
      if (bit_en) begin
        unique case ({mark_p, mark_n})
          2'b11: sym_o <= '{data: 1'b0, viol: 1'b0, illegal: 1'b1};
          2'b10, 2'b01: begin
            sym_o <= '{data: 1'b0,
                       viol: have_mark_q && (last_neg_q == mark_n),
                       illegal: 1'b0};
            have_mark_q <= 1'b1;
            last_neg_q  <= mark_n;
          end
          default: sym_o <= SYM_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcv_align_tracker.sv
module lcv_align_tracker
  import lcv_pkg::*;
#(
  parameter int FRAME_LEN   = 48,
  parameter int SPAN        = 14,
  parameter int SYNC_HITS   = 3,
  parameter int LOSS_MISSES = 3,
  localparam int POS_W  = $clog2(FRAME_LEN),
  localparam int HIT_W  = $clog2(SYNC_HITS + 1),
  localparam int MISS_W = $clog2(LOSS_MISSES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             viol,
  output logic [POS_W-1:0] pos_o,
  output logic             frame_start_o,
  output logic             in_sync_o,
  output logic             err_hit_o
);
  align_state_t      st_q, st_n;
  logic [HIT_W-1:0]  hits_q, hits_n;
  logic [MISS_W-1:0] miss_q, miss_n;
  logic              aux_q, aux_n;
  logic [POS_W-1:0]  cur_pos, pos_n;
  logic              in_window, err_hit;

  assign cur_pos   = (pos_o == POS_W'(FRAME_LEN - 1)) ? '0 : pos_o + 1'b1;
  assign in_window = (cur_pos >= POS_W'(2)) && (cur_pos <= POS_W'(SPAN)) && !aux_q;

  always_comb begin
    st_n    = st_q;
    pos_n   = cur_pos;
    hits_n  = hits_q;
    miss_n  = miss_q;
    aux_n   = (cur_pos == '0) ? 1'b0 : aux_q;
    err_hit = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (viol) begin
          st_n   = ST_CONFIRM;
          pos_n  = '0;
          hits_n = HIT_W'(1);
          aux_n  = 1'b0;
        end
      end
      ST_CONFIRM: begin
        if (cur_pos == '0) begin
          if (!viol) begin
            st_n   = ST_HUNT;
            hits_n = '0;
          end else if (hits_q + 1'b1 == HIT_W'(SYNC_HITS)) begin
            st_n   = ST_SYNC;
            hits_n = '0;
            miss_n = '0;
          end else begin
            hits_n = hits_q + 1'b1;
          end
        end
      end
      ST_SYNC: begin
        if (cur_pos == '0) begin
          if (viol) begin
            miss_n = '0;
          end else if (miss_q + 1'b1 == MISS_W'(LOSS_MISSES)) begin
            st_n   = ST_HUNT;
            miss_n = '0;
          end else begin
            miss_n = miss_q + 1'b1;
          end
        end else if (viol) begin
          if (in_window) aux_n = 1'b1;
          else           err_hit = 1'b1;
        end
      end
      default: st_n = ST_HUNT;
    endcase
  end

  assign err_hit_o = vld && err_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_HUNT;
      hits_q        <= '0;
      miss_q        <= '0;
      aux_q         <= 1'b0;
      pos_o         <= '0;
      frame_start_o <= 1'b0;
      in_sync_o     <= 1'b0;
    end else if (vld) begin
      st_q          <= st_n;
      hits_q        <= hits_n;
      miss_q        <= miss_n;
      aux_q         <= aux_n;
      pos_o         <= pos_n;
      frame_start_o <= (pos_n == '0) && (st_n != ST_HUNT);
      in_sync_o     <= (st_n == ST_SYNC);
    end
  end
endmodule

// File: rtl/lcv_sat_counter.sv
module lcv_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (inc && cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lcv_frame_sync.sv
module lcv_frame_sync
  import lcv_pkg::*;
#(
  parameter int FRAME_LEN   = 48,
  parameter bit NT_TO_TE    = 1'b1,
  parameter int SYNC_HITS   = 3,
  parameter int LOSS_MISSES = 3,
  parameter int ERR_W       = 8,
  localparam int POS_W = $clog2(FRAME_LEN),
  localparam int SPAN  = NT_TO_TE ? 14 : 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             mark_p,
  input  logic             mark_n,
  output logic             rx_data,
  output logic             viol,
  output logic             illegal,
  output logic [POS_W-1:0] bit_pos,
  output logic             frame_start,
  output logic             in_sync,
  output logic [ERR_W-1:0] err_count
);
  sym_t dec_sym, sym_q;
  logic dec_vld, err_hit;

  lcv_ami_decoder u_dec (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .mark_p    (mark_p),
    .mark_n    (mark_n),
    .sym_o     (dec_sym),
    .sym_vld_o (dec_vld)
  );

  lcv_align_tracker #(
    .FRAME_LEN   (FRAME_LEN),
    .SPAN        (SPAN),
    .SYNC_HITS   (SYNC_HITS),
    .LOSS_MISSES (LOSS_MISSES)
  ) u_align (
    .clk           (clk),
    .rst           (rst),
    .vld           (dec_vld),
    .viol          (dec_sym.viol),
    .pos_o         (bit_pos),
    .frame_start_o (frame_start),
    .in_sync_o     (in_sync),
    .err_hit_o     (err_hit)
  );

  lcv_sat_counter #(.W(ERR_W)) u_err (
    .clk (clk),
    .rst (rst),
    .inc (err_hit),
    .cnt (err_count)
  );

  always_ff @(posedge clk) begin
    if (rst)          sym_q <= SYM_IDLE;
    else if (dec_vld) sym_q <= dec_sym;
  end

  assign rx_data = sym_q.data;
  assign viol    = sym_q.viol;
  assign illegal = sym_q.illegal;
endmodule

// File: rtl/lcv_frame_sync_chk.sv
module lcv_frame_sync_chk #(
  parameter int FRAME_LEN = 48,
  parameter int ERR_W     = 8,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_data,
  input logic             viol,
  input logic             illegal,
  input logic [POS_W-1:0] bit_pos,
  input logic             frame_start,
  input logic             in_sync,
  input logic [ERR_W-1:0] err_count
);
  AST_ILLEGAL_NOT_VIOL: assert property (@(posedge clk) disable iff (rst) illegal |-> !viol); // R3
  AST_VIOL_IS_MARK: assert property (@(posedge clk) disable iff (rst) viol |-> !rx_data); // R2
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst) bit_pos <= POS_W'(FRAME_LEN - 1)); // R4
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst) frame_start |-> bit_pos == '0); // R4
  AST_LOCK_ON_START: assert property (@(posedge clk) disable iff (rst) $rose(in_sync) |-> frame_start); // R5
  AST_UNLOCK_AT_ZERO: assert property (@(posedge clk) disable iff (rst) $fell(in_sync) |-> bit_pos == '0); // R6
  AST_ERR_NO_DECREASE: assert property (@(posedge clk) disable iff (rst) err_count >= $past(err_count)); // R8
endmodule

bind lcv_frame_sync lcv_frame_sync_chk #(
  .FRAME_LEN (FRAME_LEN),
  .ERR_W     (ERR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_data     (rx_data),
  .viol        (viol),
  .illegal     (illegal),
  .bit_pos     (bit_pos),
  .frame_start (frame_start),
  .in_sync     (in_sync),
  .err_count   (err_count)
);

// File: tb/lcv_frame_sync_test.sv
module lcv_frame_sync_test;
  localparam int FL = 48;
  localparam int K_SP = 0, K_MK = 1, K_VI = 2, K_IL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, mark_p = 1'b0, mark_n = 1'b0;
  logic       rx_data, viol, illegal, frame_start, in_sync;
  logic [5:0] bit_pos;
  logic [7:0] err_count;
  logic       rx_data_b, viol_b, illegal_b, frame_start_b, in_sync_b;
  logic [5:0] bit_pos_b;
  logic [7:0] err_count_b;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit last_neg = 1'b1;
  int exp_err = 0, exp_err_b = 0;

  always #10 clk = ~clk;

  lcv_frame_sync #(.FRAME_LEN(FL), .NT_TO_TE(1'b1)) uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mark_p(mark_p), .mark_n(mark_n),
    .rx_data(rx_data), .viol(viol), .illegal(illegal), .bit_pos(bit_pos),
    .frame_start(frame_start), .in_sync(in_sync), .err_count(err_count));

  lcv_frame_sync #(.FRAME_LEN(FL), .NT_TO_TE(1'b0)) uut_te (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mark_p(mark_p), .mark_n(mark_n),
    .rx_data(rx_data_b), .viol(viol_b), .illegal(illegal_b), .bit_pos(bit_pos_b),
    .frame_start(frame_start_b), .in_sync(in_sync_b), .err_count(err_count_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    last_neg = 1'b1;
    exp_err = 0;
    exp_err_b = 0;
  endtask

  task automatic send(input int kind);
    bit neg;
    @(negedge clk);
    case (kind)
      K_MK: begin neg = ~last_neg; last_neg = neg; mark_p = ~neg; mark_n = neg; end
      K_VI: begin neg = last_neg; mark_p = ~neg; mark_n = neg; end
      K_IL: begin mark_p = 1'b1; mark_n = 1'b1; end
      default: begin mark_p = 1'b0; mark_n = 1'b0; end
    endcase
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; mark_p = 1'b0; mark_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rx_data == (kind == K_SP), "R1 data", rx_data, kind == K_SP);
    check(viol == (kind == K_VI), "R2 viol", viol, kind == K_VI);
    check(illegal == (kind == K_IL), "R3 illegal", illegal, kind == K_IL);
  endtask

  function automatic int kind_at(int p, bit fv, int aux, int extra);
    if (p == 0) return fv ? K_VI : K_SP;
    if (p == aux || p == extra) return K_VI;
    return (p % 3 == 1) ? K_MK : K_SP;
  endfunction

  task automatic frame(input bit fv, input int aux, input int extra, input bit chk);
    for (int p = 0; p < FL; p++) begin
      send(kind_at(p, fv, aux, extra));
      if (chk) begin
        check(bit_pos == 6'(p), "R4 bit_pos", bit_pos, p);
        check(frame_start == (p == 0), "R4 frame_start", frame_start, p == 0);
      end
    end
  endtask

  task automatic err_frame(input int aux, input int extra);
    exp_err   += ((aux < 2 || aux > 14) ? 1 : 0) + (extra >= 0 ? 1 : 0);
    exp_err_b += ((aux < 2 || aux > 13) ? 1 : 0) + (extra >= 0 ? 1 : 0);
    frame(1'b1, aux, extra, 1'b1);
    check(err_count == 8'(exp_err), "R8 err nt", err_count, exp_err);
    check(err_count_b == 8'(exp_err_b), "R7 err te", err_count_b, exp_err_b);
    check(in_sync == 1'b1, "R5 locked", in_sync, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(rx_data == 1'b1, "R9 rx_data", rx_data, 1);
    check(viol == 1'b0 && illegal == 1'b0, "R9 flags", {viol, illegal}, 0);
    check(bit_pos == 0 && frame_start == 1'b0, "R9 pos", bit_pos, 0);
    check(in_sync == 1'b0 && err_count == 0, "R9 sync/err", err_count, 0);

    // R1 R2 R3 decoding patterns
    send(K_MK); send(K_SP); send(K_MK); send(K_VI); send(K_MK);
    send(K_IL); send(K_MK); send(K_SP); send(K_VI); send(K_IL); send(K_VI);
    send(K_SP); send(K_MK); send(K_MK);

    do_reset();
    send(K_MK); send(K_SP); send(K_SP); send(K_SP);
    // R5 acquisition over three frames
    frame(1'b1, 5, -1, 1'b1);
    check(in_sync == 1'b0, "R5 after one", in_sync, 0);
    frame(1'b1, 5, -1, 1'b1);
    check(in_sync == 1'b0, "R5 after two", in_sync, 0);
    send(K_VI);
    check(in_sync == 1'b1, "R5 lock at third", in_sync, 1);
    check(frame_start == 1'b1, "R4 start at lock", frame_start, 1);
    for (int p = 1; p < FL; p++) send(kind_at(p, 1'b1, 5, -1));
    check(err_count == 0 && err_count_b == 0, "R7 no err", err_count, 0);

    // R7 R8 window and error sweep
    err_frame(5, 20);
    err_frame(14, -1);
    err_frame(15, -1);
    err_frame(13, -1);
    err_frame(5, 9);
    err_frame(2, -1);
    err_frame(1, -1);
    err_frame(5, 47);

    // R6 loss after three frames lacking the framing violation
    frame(1'b0, 5, -1, 1'b1);
    check(in_sync == 1'b1, "R6 one miss", in_sync, 1);
    frame(1'b0, 5, -1, 1'b1);
    check(in_sync == 1'b1, "R6 two misses", in_sync, 1);
    send(K_SP);
    check(in_sync == 1'b0, "R6 unlock", in_sync, 0);
    check(frame_start == 1'b0, "R6 no start", frame_start, 0);
    check(bit_pos == 0, "R6 pos", bit_pos, 0);
    check(err_count == 8'(exp_err), "R8 err held", err_count, exp_err);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule